// File: doc/BRIEF.md
# Systolic Three-Tap Convolution Array

This block computes a one-dimensional convolution over a stream of signed samples with a linear chain of processing cells. For the window that begins at sample i, the result is the sum over taps j of weight[j] times sample x(i+j). Tap 0 multiplies the oldest sample of the window. Each sample enters the array once, at the first cell. It then moves down the chain through a two-register delay in each cell. Partial sums move one cell per cycle in the same direction, so every cell meets the sample its tap needs without any further fetch. Adding cells adds taps, and the input still takes one sample per cycle.

Each cell keeps its own tap weight stationary in a small local bank of alternative weights. Inside a cell, the multiply and the accumulate sit in separate register stages, so one sample's product is formed while an earlier partial sum is being added. A bank-select input travels down the chain with the data. Every result is therefore computed with a single weight bank: the bank chosen when the newest sample of its window was presented. This lets the filter switch coefficient sets between consecutive samples, which suits adaptive filtering.

Top module: `sysconv_array`

## Requirements
- R1: While reset is held and on its release, `y_valid` is 0 and `y_out` is 0, and every stored weight is 0. Streaming before any weight load therefore yields valid results equal to 0.
- R2: A result for the window whose newest sample was accepted at clock edge e appears on `y_out` after clock edge e+NTAPS. Its value is the sum over j = 0..NTAPS-1 of weight[j] × x(e-(NTAPS-1-j)), where tap j = 0 pairs with the oldest sample of the window.
- R3: `y_out` is exact in two's complement at ACCW = XW+WW+ceil(log2(NTAPS)) bits (34 by default). This holds for every combination of extreme inputs and weights, including -32768 × -32768 on all taps.
- R4: `y_valid` is 1 for exactly those windows whose NTAPS samples were all presented with `in_valid` = 1 on consecutive clock edges. After reset or after any cycle with `in_valid` = 0, no result is valid until NTAPS consecutive valid samples have arrived again.
- R5: When `wld_en` = 1 at a clock edge, `wld_data` is written into the weight of tap `wld_tap`, bank `wld_bank`. Products formed from the following edge onward use the new value.
- R6: Each result uses only bank `bank_sel` as sampled with the newest sample of its window, on every tap. `bank_sel` may change on every sample without any result mixing banks.
- R7: A weight write with `wld_tap` ≥ NTAPS (value 3 by default) changes no weight. A write to a bank other than the one in use leaves the results being produced unchanged.
- R8: During an uninterrupted run of K ≥ NTAPS valid samples, exactly K-NTAPS+1 valid results appear, one per cycle with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample on `in_x` is part of the stream |
| in_x | input | XW (16) | Signed input sample |
| bank_sel | input | BANKW (1) | Weight bank for the window ending with this sample |
| wld_en | input | 1 | Weight write strobe |
| wld_tap | input | TAPW (2) | Tap index of the weight written |
| wld_bank | input | BANKW (1) | Bank of the weight written |
| wld_data | input | WW (16) | Signed weight value |
| y_valid | output | 1 | `y_out` holds a complete result |
| y_out | output | ACCW (34) | Signed convolution result |

## Verification
The main function is tried with four kinds of input. A rising ramp under small distinct weights shows whether taps are paired with the right samples or in reversed order. Extreme values of both signs on samples and weights separate an exact wide accumulator from one that wraps or truncates. Streams with holes of various lengths separate correct fill and refill timing from a tracker that counts samples rather than consecutive edges. Alternating and blocked bank selection, together with writes to the idle bank and to a nonexistent tap, catch results that mix coefficient sets or writes that land on the wrong weight. A long random sweep with random gaps, banks and full-range values then compares every cycle against the arithmetic formula.

// File: rtl/sysconv_pkg.sv
package sysconv_pkg;

   // Result width that can hold NTAPS full-scale products without wrap.
   function automatic int acc_width(input int xw, input int ww, input int taps);
      return xw + ww + $clog2(taps);
   endfunction

   // Width of an index over n entries, at least one bit.
   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sysconv_cell.sv
module sysconv_cell #(
   parameter int XW     = 16,
   parameter int WW     = 16,
   parameter int ACCW   = 34,
   parameter int NBANKS = 2,
   parameter int BANKW  = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [XW-1:0]    x_in,
   output logic signed [XW-1:0]    x_out,
   input  logic [BANKW-1:0]        bank_in,
   output logic [BANKW-1:0]        bank_out,
   input  logic signed [ACCW-1:0]  psum_in,
   output logic signed [ACCW-1:0]  psum_out,
   input  logic                    wr_en,
   input  logic [BANKW-1:0]        wr_bank,
   input  logic signed [WW-1:0]    wr_data
);
   localparam int PW = XW + WW;

   logic signed [XW-1:0]   x_d1, x_d2;
   logic signed [WW-1:0]   w_act;
   logic signed [PW-1:0]   prod_q;
   logic signed [PW-1:0]   prod_d;
   logic signed [ACCW-1:0] prod_ext;

   // Weight storage: a variant per bank count.
   generate
      if (NBANKS == 1) begin : g_single
         logic signed [WW-1:0] w_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     w_q <= '0;
            else if (wr_en) w_q <= wr_data;
         end
         assign w_act = w_q;

         a_r5_weight_write: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (w_act == $past(wr_data)));
      end else begin : g_banked
         logic signed [WW-1:0] w_q [NBANKS];
         for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            always_ff @(posedge clk) begin
               if (!rst_n)
                  w_q[b] <= '0;
               else if (wr_en && (wr_bank == BANKW'(b)))
                  w_q[b] <= wr_data;
            end
         end
         assign w_act = (int'(bank_in) < NBANKS) ? w_q[bank_in] : '0;

         // R5: a write is readable from the bank it targeted on the next cycle
         a_r5_weight_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (int'(wr_bank) < NBANKS)) |=> (w_q[$past(wr_bank)] == $past(wr_data)));
      end
   endgenerate

   assign prod_d   = $signed({{WW{x_in[XW-1]}}, x_in}) * $signed({{XW{w_act[WW-1]}}, w_act});
   assign prod_ext = {{(ACCW-PW){prod_q[PW-1]}}, prod_q};

   // Stage 1 multiplies, stage 2 accumulates; sample moves on through two registers.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_d1     <= '0;
         x_d2     <= '0;
         bank_out <= '0;
         prod_q   <= '0;
         psum_out <= '0;
      end else begin
         x_d1     <= x_in;
         x_d2     <= x_d1;
         bank_out <= bank_in;
         prod_q   <= prod_d;
         psum_out <= psum_in + prod_ext;
      end
   end

   assign x_out = x_d2;

   // R3: the accumulate never wraps: operands of equal sign give a result of that sign
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> !((!$past(psum_in[ACCW-1]) && !$past(prod_q[PW-1]) && psum_out[ACCW-1]) ||
                 ($past(psum_in[ACCW-1]) && $past(prod_q[PW-1]) && !psum_out[ACCW-1])));

endmodule

// File: rtl/sysconv_vtrack.sv
module sysconv_vtrack #(
   parameter int NTAPS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   output logic y_valid
);
   localparam int CW    = $clog2(NTAPS + 1);
   localparam int DEPTH = NTAPS + 1;
   localparam int AGEW  = $clog2(NTAPS + 2) + 1;

   logic [CW-1:0]    run_q;
   logic             ok_now;
   logic [DEPTH-1:0] vpipe;

   // run_q counts consecutive valid edges just before this one, saturating.
   assign ok_now = in_valid && (run_q >= CW'(NTAPS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         vpipe <= '0;
      end else begin
         if (!in_valid)                       run_q <= '0;
         else if (run_q != CW'(NTAPS - 1))    run_q <= run_q + 1'b1;
         vpipe <= {vpipe[DEPTH-2:0], ok_now};
      end
   end

   assign y_valid = vpipe[DEPTH-1];

   // Checker window: age since the last drop of in_valid.
   logic            prev_v;
   logic [AGEW-1:0] gap_age;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_v  <= 1'b0;
         gap_age <= '0;
      end else begin
         prev_v <= in_valid;
         if (prev_v && !in_valid)               gap_age <= AGEW'(1);
         else if (gap_age == AGEW'(NTAPS + 1))  gap_age <= '0;
         else if (gap_age != '0)                gap_age <= gap_age + 1'b1;
      end
   end

   // R4: the result whose newest slot was the invalid cycle must not be flagged valid
   a_r4_gap_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_age == AGEW'(NTAPS + 1)) |-> !y_valid);

endmodule

// File: rtl/sysconv_array.sv
module sysconv_array #(
   parameter int XW     = 16,
   parameter int WW     = 16,
   parameter int NTAPS  = 3,
   parameter int NBANKS = 2,
   parameter int ACCW   = sysconv_pkg::acc_width(XW, WW, NTAPS),
   parameter int BANKW  = sysconv_pkg::sel_width(NBANKS),
   parameter int TAPW   = sysconv_pkg::sel_width(NTAPS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [XW-1:0]   in_x,
   input  logic [BANKW-1:0]       bank_sel,
   input  logic                   wld_en,
   input  logic [TAPW-1:0]        wld_tap,
   input  logic [BANKW-1:0]       wld_bank,
   input  logic signed [WW-1:0]   wld_data,
   output logic                   y_valid,
   output logic signed [ACCW-1:0] y_out
);
   generate
      if (NTAPS < 2)                                       $error("NTAPS must be at least 2");
      if (NBANKS < 1)                                      $error("NBANKS must be at least 1");
      if (ACCW < sysconv_pkg::acc_width(XW, WW, NTAPS))    $error("ACCW too narrow for exact sums");
      if (BANKW != sysconv_pkg::sel_width(NBANKS))         $error("BANKW must match NBANKS");
      if (TAPW != sysconv_pkg::sel_width(NTAPS))           $error("TAPW must match NTAPS");
   endgenerate

   logic signed [XW-1:0]   x_link    [NTAPS+1];
   logic [BANKW-1:0]       bank_link [NTAPS+1];
   logic signed [ACCW-1:0] sum_link  [NTAPS+1];

   assign x_link[0]    = in_x;
   assign bank_link[0] = bank_sel;
   assign sum_link[0]  = '0;

   // Cell k holds tap NTAPS-1-k: the first cell sees the newest sample.
   generate
      for (genvar k = 0; k < NTAPS; k++) begin : g_cell
         localparam logic [TAPW-1:0] TAP_ID = TAPW'(NTAPS - 1 - k);
         logic wr_hit;
         assign wr_hit = wld_en && (wld_tap == TAP_ID);

         sysconv_cell #(
            .XW(XW), .WW(WW), .ACCW(ACCW), .NBANKS(NBANKS), .BANKW(BANKW)
         ) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .x_in     (x_link[k]),
            .x_out    (x_link[k+1]),
            .bank_in  (bank_link[k]),
            .bank_out (bank_link[k+1]),
            .psum_in  (sum_link[k]),
            .psum_out (sum_link[k+1]),
            .wr_en    (wr_hit),
            .wr_bank  (wld_bank),
            .wr_data  (wld_data)
         );
      end
   endgenerate

   assign y_out = sum_link[NTAPS];

   sysconv_vtrack #(.NTAPS(NTAPS)) vtrack_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .y_valid  (y_valid)
   );

   // R1: leaving reset the output is idle and zero
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!y_valid && (y_out == '0)));

endmodule

// File: tb/sysconv_array_tb_top.sv
module sysconv_array_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NT   = 3;
   localparam int ACCW = 34;
   localparam int HN   = 8192;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   in_valid = 1'b0;
   logic signed [15:0]     in_x = '0;
   logic [0:0]             bank_sel = '0;
   logic                   wld_en = 1'b0;
   logic [1:0]             wld_tap = '0;
   logic [0:0]             wld_bank = '0;
   logic signed [15:0]     wld_data = '0;
   logic                   y_valid;
   logic signed [ACCW-1:0] y_out;

   int checks = 0;
   int errors = 0;
   int n = 0;
   int vcount = 0;
   string cur_req = "R1";

   bit                 vh [HN];
   logic signed [15:0] xh [HN];
   bit                 bh [HN];
   logic signed [15:0] wm [2][NT];

   always #(CLK_PERIOD/2) clk = ~clk;

   sysconv_array dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .bank_sel(bank_sel),
      .wld_en(wld_en), .wld_tap(wld_tap), .wld_bank(wld_bank), .wld_data(wld_data),
      .y_valid(y_valid), .y_out(y_out)
   );

   task automatic fail_line(input string req, input string what, input longint act, input longint exp);
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, n);
   endtask

   // Compare outputs produced by posedge n-1: newest sample index n-1-NT.
   task automatic check_out();
      int e;
      bit ev;
      longint s;
      logic signed [ACCW-1:0] ey;
      e  = n - 1 - NT;
      ev = (e - (NT - 1)) >= 0;
      if (ev) for (int k = 0; k < NT; k++) if (!vh[e-k]) ev = 1'b0;
      checks++;
      if (y_valid !== ev) fail_line(cur_req, "y_valid", longint'(y_valid), longint'(ev));
      if (y_valid) vcount++;
      if (ev) begin
         s = 0;
         for (int j = 0; j < NT; j++)
            s += longint'(wm[bh[e]][j]) * longint'(xh[e-(NT-1-j)]);
         ey = ACCW'(s);
         checks++;
         if (y_out !== ey) fail_line(cur_req, "y_out", longint'(y_out), longint'(ey));
      end
   endtask

   task automatic step(input bit v, input logic signed [15:0] x, input bit b,
                       input bit we, input int tap, input bit wb, input logic signed [15:0] wd);
      @(negedge clk);
      check_out();
      in_valid = v; in_x = x; bank_sel = b;
      wld_en = we; wld_tap = tap[1:0]; wld_bank = wb; wld_data = wd;
      vh[n] = v; xh[n] = x; bh[n] = b;
      @(posedge clk);
      #1;
      if (we && tap < NT) wm[wb][tap] = wd;
      n++;
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) step(1'b0, '0, 1'b0, 1'b0, 0, 1'b0, '0);
   endtask

   task automatic load(input bit bank, input logic signed [15:0] w0,
                       input logic signed [15:0] w1, input logic signed [15:0] w2);
      step(1'b0, '0, 1'b0, 1'b1, 0, bank, w0);
      step(1'b0, '0, 1'b0, 1'b1, 1, bank, w1);
      step(1'b0, '0, 1'b0, 1'b1, 2, bank, w2);
      idle(2 * NT);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int b = 0; b < 2; b++) for (int j = 0; j < NT; j++) wm[b][j] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      checks++;
      if (y_valid !== 1'b0) fail_line("R1", "y_valid in reset", longint'(y_valid), 0);
      checks++;
      if (y_out !== '0) fail_line("R1", "y_out in reset", longint'(y_out), 0);
      rst_n = 1'b1;

      // R1: weights start at zero, so valid results are zero
      cur_req = "R1";
      for (int i = 0; i < 6; i++) step(1'b1, 16'(100 + i), 1'b0, 1'b0, 0, 1'b0, '0);
      idle(2 * NT);

      // R2 and R8: ramp through distinct weights, continuous run
      cur_req = "R5";
      load(1'b0, 16'sd1, 16'sd2, 16'sd3);
      cur_req = "R2";
      vcount = 0;
      for (int i = 1; i <= 12; i++) step(1'b1, 16'(i), 1'b0, 1'b0, 0, 1'b0, '0);
      idle(2 * NT);
      checks++;
      if (vcount != 12 - NT + 1) fail_line("R8", "results in a 12-sample run", vcount, 12 - NT + 1);

      // R5: rewrite one tap, the next stream uses it
      cur_req = "R5";
      step(1'b0, '0, 1'b0, 1'b1, 1, 1'b0, 16'sd7);
      idle(2 * NT);
      for (int i = 0; i < 6; i++) step(1'b1, 16'(i * 3 - 5), 1'b0, 1'b0, 0, 1'b0, '0);
      idle(2 * NT);

      // R4: holes of several lengths
      cur_req = "R4";
      begin
         bit pat [24] = '{1,1,0,1,1,1,0,0,1,1,1,1,0,1,0,1,1,0,1,1,1,1,1,0};
         for (int i = 0; i < 24; i++) step(pat[i], 16'(i * 11 - 40), 1'b0, 1'b0, 0, 1'b0, '0);
      end
      idle(2 * NT);

      // R6: second bank, alternating and blocked selection
      cur_req = "R6";
      load(1'b1, -16'sd4, 16'sd9, -16'sd2);
      for (int i = 0; i < 16; i++) step(1'b1, 16'(i * 7 - 30), i[0], 1'b0, 0, 1'b0, '0);
      for (int i = 0; i < 16; i++) step(1'b1, 16'(50 - i * 5), i[2], 1'b0, 0, 1'b0, '0);
      idle(2 * NT);

      // R7: idle-bank writes and an out-of-range tap during a bank-0 stream
      cur_req = "R7";
      for (int i = 0; i < 12; i++) begin
         if (i % 3 == 0)      step(1'b1, 16'(i + 2), 1'b0, 1'b1, 3, 1'b0, 16'sh1234);
         else if (i % 3 == 1) step(1'b1, 16'(i + 2), 1'b0, 1'b1, i % NT, 1'b1, 16'(i * 100));
         else                 step(1'b1, 16'(i + 2), 1'b0, 1'b1, 3, 1'b1, -16'sd77);
      end
      idle(2 * NT);
      for (int i = 0; i < 8; i++) step(1'b1, 16'(i - 3), 1'b1, 1'b0, 0, 1'b0, '0);
      idle(2 * NT);

      // R3: full-scale values
      cur_req = "R3";
      load(1'b0, -16'sd32768, -16'sd32768, -16'sd32768);
      for (int i = 0; i < 5; i++) step(1'b1, -16'sd32768, 1'b0, 1'b0, 0, 1'b0, '0);
      for (int i = 0; i < 5; i++) step(1'b1, i[0] ? 16'sd32767 : -16'sd32768, 1'b0, 1'b0, 0, 1'b0, '0);
      idle(2 * NT);
      load(1'b1, 16'sd32767, 16'sd32767, 16'sd32767);
      for (int i = 0; i < 6; i++) step(1'b1, -16'sd32768, 1'b1, 1'b0, 0, 1'b0, '0);
      idle(2 * NT);

      // R2: random sweep with random gaps and banks
      cur_req = "R2";
      for (int r = 0; r < 6; r++) begin
         load(1'b0, 16'($urandom), 16'($urandom), 16'($urandom));
         load(1'b1, 16'($urandom), 16'($urandom), 16'($urandom));
         for (int i = 0; i < 150; i++)
            step(($urandom % 5) != 0, 16'($urandom), 1'($urandom), 1'b0, 0, 1'b0, '0);
         idle(2 * NT);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule